// File: doc/BRIEF.md
# Oversampling Word Clock Generator

This block derives the timing of a delta-sigma converter from one data clock. A free-running divide-by-four sequencer drives two non-overlapping sampling phases for the switched-capacitor modulator, plus a one-cycle bit enable for the decimation filter at the 1-bit oversample rate. A down-counting pulse-width counter, whose period is four times the decimation rate, produces the word clock. The word clock can also be used as a pin output. The block also raises an end-of-sample pulse and keeps a sticky data-ready flag.

The decimation rate is chosen by a 2-bit select (D = 32 · 2^sel, so 32, 64, 128 or 256). A compare value sets how long the word clock stays high in each period. A compare value of zero stops the word clock while the phases keep running. The first two samples after a restart from zero are marked for discard. A swap input moves input acquisition to the other phase. Dropping the enable holds the counter, silences all timing outputs and asks the modulator to reset its integrators.

Top module: `owc_word_clk_gen`

## Requirements
- R1: While enable is high, the phase sequencer steps through four cycles numbered 0..3, starting at 0 in the first enabled cycle. Acquisition is high in step 1 and transfer in step 3, never both at once. Bit enable is high in step 3 only.
- R2: The counter period is 4·D cycles with D = 32 << dec_sel. After enable rises, the counter starts at 4·D−1 and reaches terminal count (zero) 4·D−1 cycles later. It then reloads.
- R3: sample_irq is a one-cycle pulse in each terminal-count cycle whose active compare value is nonzero. A falling edge of word_clk while enable stays high happens only in a terminal-count cycle.
- R4: word_clk is high while the counter value lies in 1..C, where C is the active compare value. This gives C high cycles per period. Any C of 4·D−1 or more keeps it high in every cycle except terminal count.
- R5: With an active compare value of 0, word_clk and sample_irq stay low while the phases and bit enable continue.
- R6: A new compare value or decimation select takes effect only at a reload: terminal count, or any cycle with enable low.
- R7: With phase_swap high, acquisition moves to step 3 and transfer to step 1.
- R8: data_rdy rises the cycle after sample_irq and holds until flag_clr. A flag_clr in the same cycle as sample_irq leaves it set.
- R9: When a reload at terminal count changes the active compare value from 0 to nonzero, discard goes high on the next cycle. It stays high through the next two sample_irq pulses and falls the cycle after the second.
- R10: With enable low, all phase, bit, word and interrupt outputs are low, integ_rst is high and discard is cleared. data_rdy keeps its value. Re-enabling starts a full period.
- R11: After reset, data_rdy and discard are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the converter timing |
| dec_sel_i | input | 2 | Decimation select, D = 32 << dec_sel |
| pulse_cmp_i | input | 10 | Word-clock high-time compare value |
| phase_swap_i | input | 1 | Acquire on the second phase |
| flag_clr_i | input | 1 | Clear the data-ready flag |
| acq_ph_o | output | 1 | Input acquisition phase |
| xfer_ph_o | output | 1 | Charge transfer phase |
| bit_en_o | output | 1 | 1-bit sample enable for the filter |
| word_clk_o | output | 1 | Word clock / pulse-width output |
| sample_irq_o | output | 1 | End-of-sample pulse |
| data_rdy_o | output | 1 | Sticky sample-available flag |
| discard_o | output | 1 | Current samples are invalid |
| integ_rst_o | output | 1 | Integrator reset request |

## Verification
A wrong counter value shows at word_clk within one period, as a shifted rising edge or a missing fall at terminal count. It also shows as a sample_irq off by a cycle. A phase sequencer out of step shows on acquisition, transfer or bit enable within four cycles. A compare value applied too early alters the high time of the current period. A stale discard or data-ready state shows at the next sample pulse. The bench compares every output against a behavioural position-in-period model on every cycle, so any of these shows in the cycle it happens.

// File: rtl/owc_pkg.sv
package owc_pkg;
  // Steps of the divide-by-four sequencer; order is behaviour.
  typedef enum logic [1:0] {
    STEP_GAP0 = 2'd0,
    STEP_A    = 2'd1,
    STEP_GAP2 = 2'd2,
    STEP_B    = 2'd3
  } ph_step_e;
endpackage

// File: rtl/owc_phase_gen.sv
module owc_phase_gen
  import owc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic swap_i,
  output logic acq_o,
  output logic xfer_o,
  output logic bit_en_o
);
  ph_step_e step_q, step_d;

  always_comb begin
    if (run_i) step_d = ph_step_e'(step_q + 2'd1);
    else       step_d = STEP_GAP0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) step_q <= STEP_GAP0;
    else         step_q <= step_d;
  end

  logic in_a, in_b;
  assign in_a     = run_i && (step_q == STEP_A);
  assign in_b     = run_i && (step_q == STEP_B);
  assign acq_o    = swap_i ? in_b : in_a;
  assign xfer_o   = swap_i ? in_a : in_b;
  assign bit_en_o = in_b;

  // R1
  phases_disjoint_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({acq_o, xfer_o}));
  // R1
  bit_en_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_o |=> !bit_en_o);
  // R7
  xfer_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> !xfer_o);
endmodule

// File: rtl/owc_pwm.sv
module owc_pwm #(
  parameter int DEC_MIN_LOG = 5,
  parameter int DEC_SEL_W   = 2,
  parameter int CNT_W       = 10
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 run_i,
  input  logic [DEC_SEL_W-1:0] dec_sel_i,
  input  logic [CNT_W-1:0]     cmp_i,
  output logic                 word_o,
  output logic                 irq_o,
  output logic                 resume_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [CNT_W:0]   span_w;
  logic [CNT_W-1:0] reload_w;
  logic             tc_w;

  // period length 4*D = 2^(DEC_MIN_LOG + 2 + sel)
  assign span_w   = {{CNT_W{1'b0}}, 1'b1} << (DEC_MIN_LOG + 2 + int'(dec_sel_i));
  assign reload_w = span_w[CNT_W-1:0] - {{(CNT_W-1){1'b0}}, 1'b1};
  assign tc_w     = run_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    cmp_d = cmp_q;
    if (!run_i || tc_w) begin
      cnt_d = reload_w;
      cmp_d = cmp_i;
    end else begin
      cnt_d = cnt_q - {{(CNT_W-1){1'b0}}, 1'b1};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cmp_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cmp_q <= cmp_d;
    end
  end

  assign word_o   = run_i && (cnt_q != '0) && (cnt_q <= cmp_q);
  assign irq_o    = tc_w && (cmp_q != '0);
  assign resume_o = tc_w && (cmp_q == '0) && (cmp_i != '0);

  // R2
  reload_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_w |=> (cnt_q != '0));
  // R3
  word_fall_at_tc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $fell(word_o)) |-> tc_w);
  // R3
  irq_word_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !word_o);
  // R6
  cmp_shadow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && !$past(tc_w)) |-> $stable(cmp_q));
endmodule

// File: rtl/owc_sample_flags.sv
module owc_sample_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic irq_i,
  input  logic clr_i,
  input  logic resume_i,
  output logic rdy_o,
  output logic discard_o
);
  logic       rdy_q, rdy_d;
  logic [1:0] skip_q, skip_d;

  always_comb begin
    rdy_d  = irq_i | (rdy_q & ~clr_i);
    skip_d = skip_q;
    if (!run_i)                       skip_d = 2'd0;
    else if (resume_i)                skip_d = 2'd2;
    else if (irq_i && skip_q != 2'd0) skip_d = skip_q - 2'd1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q  <= 1'b0;
      skip_q <= 2'd0;
    end else begin
      rdy_q  <= rdy_d;
      skip_q <= skip_d;
    end
  end

  assign rdy_o     = rdy_q;
  assign discard_o = (skip_q != 2'd0);

  // R8
  rdy_after_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> rdy_o);
  // R9
  discard_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i) && $fell(discard_o)) |-> $past(irq_i));
endmodule

// File: rtl/owc_word_clk_gen.sv
module owc_word_clk_gen #(
  parameter int DEC_MIN_LOG = 5,
  parameter int DEC_SEL_W   = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = DEC_MIN_LOG + 2 + (1 << DEC_SEL_W) - 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 enable_i,
  input  logic [DEC_SEL_W-1:0] dec_sel_i,
  input  logic [CNT_W-1:0]     pulse_cmp_i,
  input  logic                 phase_swap_i,
  input  logic                 flag_clr_i,
  output logic                 acq_ph_o,
  output logic                 xfer_ph_o,
  output logic                 bit_en_o,
  output logic                 word_clk_o,
  output logic                 sample_irq_o,
  output logic                 data_rdy_o,
  output logic                 discard_o,
  output logic                 integ_rst_o
);
  // asynchronous assertion, synchronous release
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[SYNC_STAGES-1];

  logic resume_w;

  owc_phase_gen u_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .run_i    (enable_i),
    .swap_i   (phase_swap_i),
    .acq_o    (acq_ph_o),
    .xfer_o   (xfer_ph_o),
    .bit_en_o (bit_en_o)
  );

  owc_pwm #(
    .DEC_MIN_LOG (DEC_MIN_LOG),
    .DEC_SEL_W   (DEC_SEL_W),
    .CNT_W       (CNT_W)
  ) u_pwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .run_i     (enable_i),
    .dec_sel_i (dec_sel_i),
    .cmp_i     (pulse_cmp_i),
    .word_o    (word_clk_o),
    .irq_o     (sample_irq_o),
    .resume_o  (resume_w)
  );

  owc_sample_flags u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .run_i     (enable_i),
    .irq_i     (sample_irq_o),
    .clr_i     (flag_clr_i),
    .resume_i  (resume_w),
    .rdy_o     (data_rdy_o),
    .discard_o (discard_o)
  );

  assign integ_rst_o = ~enable_i;

  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !enable_i |-> !(word_clk_o || sample_irq_o || acq_ph_o || xfer_ph_o || bit_en_o));
  // R1
  bit_en_with_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    bit_en_o |-> (acq_ph_o || xfer_ph_o));
endmodule

// File: tb/owc_word_clk_gen_tb_top.sv
module owc_word_clk_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, swap, clr;
  logic [1:0] dsel;
  logic [9:0] cmp;
  logic acq, xfer, bit_en, word, irq, rdy, disc, irst;

  int compared = 0;
  int mismatched = 0;

  // behavioural model: position within the current period
  int m_pos = 0, m_len = 128, m_cmp = 0, m_skip = 0;
  bit m_rdy = 1'b0;

  always #4 clk = ~clk;

  owc_word_clk_gen dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .dec_sel_i(dsel),
    .pulse_cmp_i(cmp), .phase_swap_i(swap), .flag_clr_i(clr),
    .acq_ph_o(acq), .xfer_ph_o(xfer), .bit_en_o(bit_en), .word_clk_o(word),
    .sample_irq_o(irq), .data_rdy_o(rdy), .discard_o(disc), .integ_rst_o(irst)
  );

  task automatic chk(input string tag, input string nm, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, nm, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit last, fire;
    if (!rst_n) begin
      m_rdy = 0; m_skip = 0; m_pos = 0;
      return;
    end
    if (!en) begin
      m_pos = 0; m_len = 128 << dsel; m_cmp = int'(cmp); m_skip = 0;
      m_rdy = m_rdy & !clr;
      return;
    end
    last = (m_pos == m_len - 1);
    fire = last && (m_cmp != 0);
    m_rdy = fire | (m_rdy & !clr);
    if (last) begin
      if (fire && m_skip > 0) m_skip--;
      if (m_cmp == 0 && cmp != 0) m_skip = 2;
      m_cmp = int'(cmp); m_len = 128 << dsel; m_pos = 0;
    end else m_pos++;
  endtask

  task automatic compare_all();
    int step, left;
    bit e_acq, e_xfer, e_word, e_irq;
    step  = m_pos % 4;
    left  = m_len - 1 - m_pos;
    e_acq  = en && ((!swap && step == 1) || (swap && step == 3));   // R1 R7
    e_xfer = en && ((!swap && step == 3) || (swap && step == 1));
    e_word = en && left != 0 && left <= m_cmp;                       // R4 R5 R6
    e_irq  = en && left == 0 && m_cmp != 0;                          // R2 R3
    chk("R7", "acq_ph", acq, e_acq);
    chk("R1", "xfer_ph", xfer, e_xfer);
    chk("R1", "bit_en", bit_en, en && step == 3);
    chk("R4", "word_clk", word, e_word);
    chk("R3", "sample_irq", irq, e_irq);
    chk("R8", "data_rdy", rdy, m_rdy);
    chk("R9", "discard", disc, m_skip != 0);
    chk("R10", "integ_rst", irst, !en);
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    #(200000 * 8);
    mismatched++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; en = 0; swap = 0; clr = 0; dsel = 2'd0; cmp = 10'd64;
    repeat (3) tick();
    // R11: reset state
    chk("R11", "data_rdy_reset", rdy, 0);
    chk("R11", "discard_reset", disc, 0);
    rst_n = 1;
    repeat (5) tick();
    // R2 R3 R4 R1: basic run at D=32
    en = 1;
    repeat (400) tick();
    // R8: ordinary clear
    clr = 1; tick(); clr = 0;
    chk("R8", "rdy_cleared", rdy, 0);
    repeat (30) tick();
    // R8: clear coinciding with terminal count
    for (int i = 0; i < 600 && m_pos != m_len - 1; i++) tick();
    clr = 1; tick(); clr = 0;
    chk("R8", "rdy_clear_vs_irq", rdy, 1);
    // R6: mid-period compare change, then R5: zero compare
    repeat (40) tick();
    cmp = 10'd0;
    repeat (400) tick();
    // R9: resume from zero compare
    cmp = 10'd20;
    repeat (600) tick();
    // R7: swapped phases
    swap = 1;
    repeat (200) tick();
    // R4: maximum compare for D=32
    cmp = 10'd127;
    repeat (300) tick();
    // R4 R6: compare beyond the period at D=64
    dsel = 2'd1; cmp = 10'd500;
    repeat (600) tick();
    // R2: largest decimation
    dsel = 2'd3; cmp = 10'd512; swap = 0;
    repeat (2200) tick();
    // R10: disable mid-period and restart
    en = 0;
    repeat (20) tick();
    chk("R10", "rdy_kept_when_idle", rdy, m_rdy);
    en = 1; dsel = 2'd0; cmp = 10'd5;
    repeat (300) tick();
    summary();
    $finish;
  end
endmodule